// File: doc/BRIEF.md
# Two-Region Paged Address Translator

The block turns a 32-bit virtual address into a 30-bit physical address. The top two address bits pick one of three regions: a program region, a downward-growing stack region and a shared system region. The fourth code is reserved. A system page is looked up with one read of a table that sits in physical memory. A program or stack page needs two reads. Its table lives in system virtual space, so the block first forms the system virtual address of the entry, then looks that address up in the system table, and only then reads the entry itself.

Software loads six base and length values through a small write port. It then issues one translation at a time over a request/response port. Page table entries are fetched through a read port whose latency may vary, and the modify bit is written back through a write port. Each response carries either the physical address or a fault cause, together with the virtual address that was presented.

Top module: `region_xlate`

## Requirements
- R1: Virtual address bits [31:30] select the region: 00 program, 01 stack, 10 system. Code 11 returns a fault with cause 1 (region) in the cycle after acceptance, and no memory read is issued.
- R2: For a system address, VPN = bits [29:9]. The entry is read from physical address SYS_BASE + 4*VPN. On success the physical address is {entry[20:0], vaddr[8:0]}.
- R3: A system address whose VPN is not below SYS_LEN returns cause 2 (length) and issues no memory read.
- R4: A program address is legal only when VPN < PROG_LEN. The entry's system virtual address is PROG_BASE + 4*VPN. That address must lie in the system region and its page number must be below SYS_LEN, or the result is cause 2. Its system entry gives a frame F, and the final entry is then read at {F, sva[8:0]}.
- R5: A stack address uses STK_BASE in the same way as R4, but it is legal only when VPN >= STK_LEN; below that value the result is cause 2.
- R6: An entry whose valid bit [31] is 0, whether it is the system-level entry or the final entry, returns cause 3 (page fault).
- R7: A user-mode request whose final entry has protection code 0 in bits [30:27] returns cause 4 (access) for a read or a write. Kernel mode is not restricted.
- R8: A successful write whose final entry has modify bit [26] clear writes the entry back to the same address with bit [26] set, before the response. Reads, and writes to an entry with the bit already set, cause no memory write.
- R9: req_ready is high only while no request is in progress. resp_valid is a single-cycle pulse and echoes the accepted virtual address. On a fault, resp_fault is 1 and resp_paddr is 0.
- R10: Configuration writes use cfg_sel codes 0 SYS_BASE, 1 SYS_LEN, 2 PROG_BASE, 3 PROG_LEN, 4 STK_BASE, 5 STK_LEN. All six registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| resp_valid | output | 1 | Response pulse |
| resp_fault | output | 1 | Translation failed |
| resp_cause | output | 3 | 0 none, 1 region, 2 length, 3 page, 4 access |
| resp_paddr | output | 30 | Translated physical address |
| resp_vaddr | output | 32 | Echo of the requested virtual address |
| mem_rd_en | output | 1 | Entry read request (one cycle) |
| mem_wr_en | output | 1 | Entry write-back strobe |
| mem_addr | output | 32 | Physical address of the entry |
| mem_wdata | output | 32 | Entry written back |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Entry read from memory |

## Verification
On every cycle the assertions check the handshake: ready only while idle, a single-cycle response pulse carrying the accepted address, no read issued while idle, and no read and write in the same cycle. They also check that a reserved address faults in the next cycle and that every write-back carries both the valid and the modify bits. The bench scenarios are needed for the walk results. Only they can show the address arithmetic of both table levels, the length limits at each region's edge including the stack's top-down limit, invalid entries at either level, the user-mode protection check, and whether the write-back happens or not.

// File: rtl/rx_pkg.sv
// Package: shared widths, entry field positions, region and fault encodings
// for the two-region translator. Assumes 512-byte pages and 32-bit entries.
package rx_pkg;
    localparam int VA_W    = 32;
    localparam int OFF_W   = 9;
    localparam int VPN_W   = 21;
    localparam int PFN_W   = 21;
    localparam int PA_W    = PFN_W + OFF_W;
    localparam int PTE_W   = 32;
    localparam int CFG_W   = 32;
    localparam int NREG    = 6;
    localparam int SEL_W   = 3;
    localparam int PTE_V   = 31;
    localparam int PTE_PH  = 30;
    localparam int PTE_PL  = 27;
    localparam int PTE_M   = 26;

    typedef enum logic [1:0] {
        RG_PROG  = 2'b00,
        RG_STACK = 2'b01,
        RG_SYS   = 2'b10,
        RG_RSVD  = 2'b11
    } region_e;

    typedef enum logic [2:0] {
        CS_NONE   = 3'd0,
        CS_REGION = 3'd1,
        CS_LENGTH = 3'd2,
        CS_PAGE   = 3'd3,
        CS_ACCESS = 3'd4
    } cause_e;

    localparam logic [SEL_W-1:0] SEL_SYS_BASE  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_SYS_LEN   = 3'd1;
    localparam logic [SEL_W-1:0] SEL_PROG_BASE = 3'd2;
    localparam logic [SEL_W-1:0] SEL_PROG_LEN  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_STK_BASE  = 3'd4;
    localparam logic [SEL_W-1:0] SEL_STK_LEN   = 3'd5;
endpackage

// File: rtl/rx_cfg_regs.sv
// Module: base and length register file. Assumes writes take effect on the
// next edge and that software does not change them during a walk.
module rx_cfg_regs
    import rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] sys_base,
    output logic [CFG_W-1:0] sys_len,
    output logic [CFG_W-1:0] prog_base,
    output logic [CFG_W-1:0] prog_len,
    output logic [CFG_W-1:0] stk_base,
    output logic [CFG_W-1:0] stk_len
);
    logic [CFG_W-1:0] reg_q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        // One register: clear on reset, load when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                reg_q[i] <= '0;
            else if (cfg_we && cfg_sel == SEL_W'(i))
                reg_q[i] <= cfg_wdata;
        end
    end

    assign sys_base  = reg_q[SEL_SYS_BASE];
    assign sys_len   = reg_q[SEL_SYS_LEN];
    assign prog_base = reg_q[SEL_PROG_BASE];
    assign prog_len  = reg_q[SEL_PROG_LEN];
    assign stk_base  = reg_q[SEL_STK_BASE];
    assign stk_len   = reg_q[SEL_STK_LEN];
endmodule

// File: rtl/rx_decode.sv
// Module: combinational front end. Decodes the region, runs the length
// checks and forms the physical address of the first (system) entry to read.
// For user regions it also yields the offset of the user entry in its page.
module rx_decode
    import rx_pkg::*;
(
    input  logic [VA_W-1:0]  vaddr,
    input  logic [CFG_W-1:0] sys_base,
    input  logic [CFG_W-1:0] sys_len,
    input  logic [CFG_W-1:0] prog_base,
    input  logic [CFG_W-1:0] prog_len,
    input  logic [CFG_W-1:0] stk_base,
    input  logic [CFG_W-1:0] stk_len,
    output logic             fault,
    output cause_e           cause,
    output logic             nested,
    output logic [VA_W-1:0]  sys_pte_addr,
    output logic [OFF_W-1:0] sva_off
);
    localparam int PAD_W = VA_W - VPN_W - 2;
    localparam int ZX_W  = VA_W - VPN_W;

    logic [1:0]       rg;
    logic [VPN_W-1:0] vpn;
    logic [VA_W-1:0]  vpn_x;
    logic [VA_W-1:0]  vpn_x4;
    logic [VA_W-1:0]  sva;
    logic [VPN_W-1:0] svpn;
    logic [VA_W-1:0]  svpn_x;
    logic             sva_ok;

    assign rg     = vaddr[VA_W-1 -: 2];
    assign vpn    = vaddr[OFF_W +: VPN_W];
    assign vpn_x  = {{ZX_W{1'b0}}, vpn};
    assign vpn_x4 = {{PAD_W{1'b0}}, vpn, 2'b00};
    assign sva    = ((rg == RG_STACK) ? stk_base : prog_base) + vpn_x4;
    assign svpn   = sva[OFF_W +: VPN_W];
    assign svpn_x = {{ZX_W{1'b0}}, svpn};
    assign sva_ok = (sva[VA_W-1 -: 2] == RG_SYS) && (svpn_x < sys_len);
    assign sva_off = sva[OFF_W-1:0];

    // Region decode, length checks and first-read address selection.
    always_comb begin
        fault        = 1'b0;
        cause        = CS_NONE;
        nested       = 1'b0;
        sys_pte_addr = sys_base + vpn_x4;
        unique case (rg)
            RG_SYS: begin
                if (!(vpn_x < sys_len)) begin
                    fault = 1'b1;
                    cause = CS_LENGTH;
                end
            end
            RG_PROG, RG_STACK: begin
                nested       = 1'b1;
                sys_pte_addr = sys_base + {svpn_x[VA_W-3:0], 2'b00};
                if (rg == RG_PROG ? !(vpn_x < prog_len) : (vpn_x < stk_len)) begin
                    fault = 1'b1;
                    cause = CS_LENGTH;
                end else if (!sva_ok) begin
                    fault = 1'b1;
                    cause = CS_LENGTH;
                end
            end
            default: begin
                fault = 1'b1;
                cause = CS_REGION;
            end
        endcase
    end
endmodule

// File: rtl/rx_walker.sv
// Module: table walk sequencer. Accepts one request at a time, reads the
// system entry, then for user regions reads the user entry, applies the
// valid and protection checks, writes back the modify bit, and responds.
// Assumes the memory returns exactly one mem_rvalid per mem_rd_en.
module rx_walker
    import rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic             req_user,
    input  logic             dec_fault,
    input  cause_e           dec_cause,
    input  logic             dec_nested,
    input  logic [VA_W-1:0]  dec_sys_addr,
    input  logic [OFF_W-1:0] dec_off,
    output logic             resp_valid,
    output logic             resp_fault,
    output logic [2:0]       resp_cause,
    output logic [PA_W-1:0]  resp_paddr,
    output logic [VA_W-1:0]  resp_vaddr,
    output logic             mem_rd_en,
    output logic             mem_wr_en,
    output logic [VA_W-1:0]  mem_addr,
    output logic [PTE_W-1:0] mem_wdata,
    input  logic             mem_rvalid,
    input  logic [PTE_W-1:0] mem_rdata
);
    localparam int AZ_W = VA_W - PA_W;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD_SYS, ST_WT_SYS, ST_RD_PTE, ST_WT_PTE, ST_WB, ST_RESP
    } state_e;

    state_e           state_q;
    logic [VA_W-1:0]  vaddr_q;
    logic [VA_W-1:0]  addr_q;
    logic [PTE_W-1:0] wdata_q;
    logic [PFN_W-1:0] pfn_q;
    logic [OFF_W-1:0] off_q;
    logic             write_q;
    logic             user_q;
    logic             nested_q;
    cause_e           cause_q;

    logic             bad_valid;
    logic             bad_prot;
    logic             need_wb;

    assign bad_valid = !mem_rdata[PTE_V];
    assign bad_prot  = user_q && (mem_rdata[PTE_PH:PTE_PL] == '0);
    assign need_wb   = write_q && !mem_rdata[PTE_M];

    // Walk sequencing and capture of request, address and result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            vaddr_q  <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
            pfn_q    <= '0;
            off_q    <= '0;
            write_q  <= 1'b0;
            user_q   <= 1'b0;
            nested_q <= 1'b0;
            cause_q  <= CS_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    vaddr_q  <= req_vaddr;
                    write_q  <= req_write;
                    user_q   <= req_user;
                    nested_q <= dec_nested;
                    addr_q   <= dec_sys_addr;
                    off_q    <= dec_off;
                    cause_q  <= dec_cause;
                    state_q  <= dec_fault ? ST_RESP : ST_RD_SYS;
                end
                ST_RD_SYS: state_q <= ST_WT_SYS;
                ST_RD_PTE: state_q <= ST_WT_PTE;
                ST_WT_SYS, ST_WT_PTE: if (mem_rvalid) begin
                    if (bad_valid) begin
                        cause_q <= CS_PAGE;
                        state_q <= ST_RESP;
                    end else if (state_q == ST_WT_SYS && nested_q) begin
                        addr_q  <= {{AZ_W{1'b0}}, mem_rdata[PFN_W-1:0], off_q};
                        state_q <= ST_RD_PTE;
                    end else if (bad_prot) begin
                        cause_q <= CS_ACCESS;
                        state_q <= ST_RESP;
                    end else begin
                        pfn_q   <= mem_rdata[PFN_W-1:0];
                        wdata_q <= mem_rdata | (PTE_W'(1) << PTE_M);
                        state_q <= need_wb ? ST_WB : ST_RESP;
                    end
                end
                ST_WB:   state_q <= ST_RESP;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign resp_valid = (state_q == ST_RESP);
    assign resp_fault = (cause_q != CS_NONE);
    assign resp_cause = cause_q;
    assign resp_paddr = resp_fault ? '0 : {pfn_q, vaddr_q[OFF_W-1:0]};
    assign resp_vaddr = vaddr_q;
    assign mem_rd_en  = (state_q == ST_RD_SYS) || (state_q == ST_RD_PTE);
    assign mem_wr_en  = (state_q == ST_WB);
    assign mem_addr   = addr_q;
    assign mem_wdata  = wdata_q;
endmodule

// File: rtl/region_xlate.sv
// Module: top of the two-region paged translator. Connects the register
// file, the region decoder and the walk sequencer. One request at a time.
module region_xlate
    import rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    input  logic        req_write,
    input  logic        req_user,
    output logic        resp_valid,
    output logic        resp_fault,
    output logic [2:0]  resp_cause,
    output logic [29:0] resp_paddr,
    output logic [31:0] resp_vaddr,
    output logic        mem_rd_en,
    output logic        mem_wr_en,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata
);
    logic [CFG_W-1:0] sys_base, sys_len, prog_base, prog_len, stk_base, stk_len;
    logic             dec_fault;
    cause_e           dec_cause;
    logic             dec_nested;
    logic [VA_W-1:0]  dec_sys_addr;
    logic [OFF_W-1:0] dec_off;

    rx_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .sys_base(sys_base), .sys_len(sys_len),
        .prog_base(prog_base), .prog_len(prog_len),
        .stk_base(stk_base), .stk_len(stk_len)
    );

    rx_decode u_dec (
        .vaddr(req_vaddr), .sys_base(sys_base), .sys_len(sys_len),
        .prog_base(prog_base), .prog_len(prog_len),
        .stk_base(stk_base), .stk_len(stk_len),
        .fault(dec_fault), .cause(dec_cause), .nested(dec_nested),
        .sys_pte_addr(dec_sys_addr), .sva_off(dec_off)
    );

    rx_walker u_walk (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user),
        .dec_fault(dec_fault), .dec_cause(dec_cause), .dec_nested(dec_nested),
        .dec_sys_addr(dec_sys_addr), .dec_off(dec_off),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_cause(resp_cause),
        .resp_paddr(resp_paddr), .resp_vaddr(resp_vaddr),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );
endmodule

// File: rtl/rx_checker.sv
// Module: protocol checker for region_xlate, bound to the top. Watches the
// handshake, the response pulse and the memory port.
module rx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_vaddr,
    input logic        resp_valid,
    input logic [2:0]  resp_cause,
    input logic [31:0] resp_vaddr,
    input logic        mem_rd_en,
    input logic        mem_wr_en,
    input logic [31:0] mem_wdata
);
    logic [31:0] held_vaddr;

    // Record the address of each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_vaddr <= '0;
        else if (req_valid && req_ready)
            held_vaddr <= req_vaddr;
    end

    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);
    a_r9_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);
    a_r9_vaddr_echo: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> resp_vaddr == held_vaddr);
    a_r9_no_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_rd_en && !mem_wr_en);
    a_r8_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));
    a_r8_wb_bits: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> mem_wdata[26] && mem_wdata[31]);
    a_r8_wb_then_resp: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> resp_valid);
    a_r1_reserved_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_vaddr[31:30] == 2'b11)
        |=> (resp_valid && resp_cause == 3'd1));
endmodule

bind region_xlate rx_checker chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .resp_valid(resp_valid), .resp_cause(resp_cause),
    .resp_vaddr(resp_vaddr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata)
);

// File: tb/region_xlate_tb_top.sv
// Bench: directed scenarios against a word memory model with one-cycle
// read latency. Each task checks its own results.
module region_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        resp_valid, resp_fault;
    logic [2:0]  resp_cause;
    logic [29:0] resp_paddr;
    logic [31:0] resp_vaddr;
    logic        mem_rd_en, mem_wr_en;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem [0:1023];
    int          n_checks = 0;
    int          n_fail = 0;
    int          rd_count = 0;
    int          wr_count = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    region_xlate dut_i (.*);

    // Memory model: one-cycle read latency, single-cycle write.
    always @(posedge clk) begin
        mem_rvalid <= mem_rd_en;
        if (mem_rd_en) begin
            mem_rdata <= mem[mem_addr[11:2]];
            rd_count  <= rd_count + 1;
        end
        if (mem_wr_en) begin
            mem[mem_addr[11:2]] <= mem_wdata;
            wr_count <= wr_count + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] pte(input bit v, input int prot, input bit m,
                                        input logic [20:0] pfn);
        return {v, 4'(prot), m, 5'b0, pfn};
    endfunction

    // Issue one request and wait for its response.
    task automatic xlate(input logic [31:0] va, input bit wr, input bit usr);
        int n = 0;
        @(negedge clk);
        rd_count = 0;
        req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R9 busy", 32'(req_ready), 0);
        while (!resp_valid && n < 40) begin
            @(negedge clk);
            n++;
        end
        check(resp_valid, "R9 response", 32'(resp_valid), 1);
        check(resp_vaddr == va, "R9 vaddr echo", resp_vaddr, va);
    endtask

    task automatic expect_ok(input string req, input logic [29:0] pa);
        check(!resp_fault && resp_cause == 3'd0, req, 32'(resp_cause), 0);
        check(resp_paddr == pa, req, 32'(resp_paddr), 32'(pa));
    endtask

    task automatic expect_fault(input string req, input logic [2:0] c);
        check(resp_fault && resp_cause == c, req, 32'(resp_cause), 32'(c));
        check(resp_paddr == '0, req, 32'(resp_paddr), 0);
    endtask

    task automatic t_reset;
        check(req_ready == 1'b1, "R9 reset ready", 32'(req_ready), 1);
        check(resp_valid == 1'b0, "R9 reset resp", 32'(resp_valid), 0);
        check(!mem_rd_en && !mem_wr_en, "R9 reset mem", 32'(mem_rd_en), 0);
    endtask

    task automatic t_reserved;  // R1
        xlate(32'hC000_1234, 1'b0, 1'b0);
        expect_fault("R1 reserved region", 3'd1);
        check(rd_count == 0, "R1 no read", rd_count, 0);
    endtask

    task automatic t_system;  // R2, R3
        xlate(32'h8000_0237, 1'b0, 1'b0);
        expect_ok("R2 system translate", {21'h12345, 9'h037});
        check(rd_count == 1, "R2 one read", rd_count, 1);
        xlate(32'h8000_0E00, 1'b0, 1'b0);
        expect_ok("R3 system last legal page", {21'h00007, 9'h000});
        xlate(32'h8000_1000, 1'b0, 1'b0);
        expect_fault("R3 system length", 3'd2);
        check(rd_count == 0, "R3 no read", rd_count, 0);
    endtask

    task automatic t_program;  // R4, R6
        xlate(32'h0000_0410, 1'b0, 1'b0);
        expect_ok("R4 program translate", {21'h00ABC, 9'h010});
        check(rd_count == 2, "R4 two reads", rd_count, 2);
        xlate(32'h0000_0800, 1'b0, 1'b0);
        expect_fault("R4 program length", 3'd2);
        xlate(32'h0000_0600, 1'b0, 1'b0);
        expect_fault("R6 final entry invalid", 3'd3);
        mem[2] = 32'h0;
        xlate(32'h0000_0410, 1'b0, 1'b0);
        expect_fault("R6 system entry invalid", 3'd3);
        check(rd_count == 1, "R6 stops after system read", rd_count, 1);
        mem[2] = pte(1, 1, 1, 21'h1);
    endtask

    task automatic t_stack;  // R5
        xlate(32'h7FFF_FE44, 1'b0, 1'b0);
        expect_ok("R5 stack top page", {21'h1F00F, 9'h044});
        xlate(32'h7FFF_F800, 1'b0, 1'b0);
        expect_ok("R5 stack lowest legal page", {21'h1F00C, 9'h000});
        xlate(32'h7FFF_F600, 1'b0, 1'b0);
        expect_fault("R5 stack below length", 3'd2);
    endtask

    task automatic t_protect;  // R7
        xlate(32'h0000_0000, 1'b0, 1'b1);
        expect_fault("R7 user read prot 0", 3'd4);
        xlate(32'h0000_0000, 1'b1, 1'b1);
        expect_fault("R7 user write prot 0", 3'd4);
        check(mem[32'h80] == pte(1, 0, 0, 21'h55), "R7 no write-back",
              mem[32'h80], pte(1, 0, 0, 21'h55));
        xlate(32'h0000_0000, 1'b0, 1'b0);
        expect_ok("R7 kernel prot 0", {21'h00055, 9'h000});
        xlate(32'h0000_0410, 1'b0, 1'b1);
        expect_ok("R7 user prot 3", {21'h00ABC, 9'h010});
    endtask

    task automatic t_modify;  // R8
        int w0;
        w0 = wr_count;
        xlate(32'h0000_0000, 1'b0, 1'b0);
        check(wr_count == w0, "R8 read no write", wr_count, w0);
        check(mem[32'h80][26] == 1'b0, "R8 read leaves M", 32'(mem[32'h80][26]), 0);
        xlate(32'h0000_0208, 1'b1, 1'b0);
        expect_ok("R8 write translate", {21'h00777, 9'h008});
        check(wr_count == w0 + 1, "R8 one write-back", wr_count, w0 + 1);
        check(mem[32'h81] == pte(1, 3, 1, 21'h777), "R8 M set",
              mem[32'h81], pte(1, 3, 1, 21'h777));
        xlate(32'h0000_0208, 1'b1, 1'b0);
        check(wr_count == w0 + 1, "R8 no second write-back", wr_count, w0 + 1);
    endtask

    task automatic t_cfg_reset;  // R10
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        xlate(32'h8000_0000, 1'b0, 1'b0);
        expect_fault("R10 lengths clear after reset", 3'd2);
    endtask

    initial begin
        #150us;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        mem[1]      = pte(1, 5, 1, 21'h12345);
        mem[2]      = pte(1, 1, 1, 21'h00001);
        mem[3]      = pte(1, 1, 1, 21'h00002);
        mem[7]      = pte(1, 1, 1, 21'h00007);
        mem[32'h80] = pte(1, 0, 0, 21'h00055);
        mem[32'h81] = pte(1, 3, 0, 21'h00777);
        mem[32'h82] = pte(1, 3, 1, 21'h00ABC);
        mem[32'h17C] = pte(1, 2, 1, 21'h1F00C);
        mem[32'h17F] = pte(1, 2, 1, 21'h1F00F);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        cfg(3'd0, 32'h0000_0000);   // R10 system base
        cfg(3'd1, 32'd8);
        cfg(3'd2, 32'h8000_0400);
        cfg(3'd3, 32'd4);
        cfg(3'd4, 32'h7F80_0800);
        cfg(3'd5, 32'h001F_FFFC);
        t_reserved();
        t_system();
        t_program();
        t_stack();
        t_protect();
        t_modify();
        t_cfg_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule